// File: doc/BRIEF.md
# Branch Next-Address Unit

This block works out where instruction fetch goes after a control-transfer operation. Each cycle it takes an operation code, a target form and the operands that the fetch stage has already collected: the current code segment and instruction pointer, the fall-through address, a displacement, a 16-bit near target and a 32-bit far pointer. It also takes a condition-true input from the flag evaluator, the zero flag and the count register. From these it produces the next code segment, the next instruction pointer, the updated count register and a taken indication.

Three kinds of target are supported. A relative target adds an 8-bit or 16-bit displacement to the instruction pointer. An absolute near target replaces the instruction pointer. A far target reloads both the segment and the pointer. The counted-loop operations decrement the count and branch on the decremented value. Two of them also require the zero flag to have a given state. The operands that reach this block have already been fetched.

All results are registered, so they appear one clock after the inputs that produced them.

Top module: `nxa_unit`

## Requirements
- R1: Operation code 0 (plain jump) is always taken.
- R2: Operation code 1 (conditional jump) is taken when `cond_i` is 1 and is not taken when `cond_i` is 0.
- R3: Target form 0 adds the sign-extended low 8 bits of `disp_i` to `ip_i`. Target form 1 adds all 16 bits of `disp_i`. Both sums wrap modulo 2^16, and a taken branch with either form keeps `cs_i` as the next segment.
- R4: Target form 2 makes `near_tgt_i` the next instruction pointer on a taken branch and keeps `cs_i` as the next segment.
- R5: Target form 3 loads bits 31:16 of `far_ptr_i` into the next segment and bits 15:0 into the next instruction pointer on a taken branch.
- R6: Operation code 2 (count loop) outputs `cx_i - 1`, wrapping from 0 to 0xFFFF. It is taken exactly when that decremented value is non-zero, so a starting count of 1 falls through.
- R7: Operation code 3 (loop while equal) decrements the count as in R6 and is taken only when the decremented count is non-zero and `zf_i` is 1.
- R8: Operation code 4 (loop while not equal) decrements the count as in R6 and is taken only when the decremented count is non-zero and `zf_i` is 0.
- R9: When no branch is taken, the next instruction pointer is `fall_ip_i` and the next segment is `cs_i`.
- R10: Operation codes 5 to 7 (no transfer) are never taken. Every non-loop operation passes `cx_i` to `cx_o` unchanged.
- R11: All outputs are registered and change only on a rising clock edge, one cycle after their inputs. While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 3 | Operation code (0 jump, 1 conditional jump, 2 loop, 3 loop-while-equal, 4 loop-while-not-equal, 5-7 none) |
| tgt_i | input | 2 | Target form (0 rel8, 1 rel16, 2 absolute near, 3 far) |
| cond_i | input | 1 | Condition result for a conditional jump |
| zf_i | input | 1 | Zero flag |
| cs_i | input | 16 | Current code segment |
| ip_i | input | 16 | Base instruction pointer for relative targets |
| fall_ip_i | input | 16 | Fall-through instruction pointer |
| disp_i | input | 16 | Displacement (the low 8 bits are used for rel8) |
| near_tgt_i | input | 16 | Absolute near target from a register or memory |
| far_ptr_i | input | 32 | Far pointer, segment:offset |
| cx_i | input | 16 | Current count register |
| next_cs_o | output | 16 | Next code segment |
| next_ip_o | output | 16 | Next instruction pointer |
| cx_o | output | 16 | Updated count register |
| taken_o | output | 1 | Branch taken |

## Verification
Every cycle, the assertions check the properties that hold for any operand values. A plain jump is always taken. A false conditional jump and a loop with an unwanted zero flag fall through. A loop that starts at a count of 1 ends at zero and is not taken. A non-loop operation leaves the count untouched. A near branch keeps the segment, and the fall-through path selects the supplied address. The exact arithmetic can only be shown by the bench's directed scenarios: sign extension of a negative 8-bit displacement, wrapping of the pointer sum past 0xFFFF, splitting of the far pointer, and the count wrapping from 0 to 0xFFFF while the loop is still taken.

// File: rtl/nxa_pkg.sv
package nxa_pkg;

  typedef enum logic [2:0] {
    OP_JMP    = 3'd0,
    OP_JCC    = 3'd1,
    OP_LOOP   = 3'd2,
    OP_LOOPE  = 3'd3,
    OP_LOOPNE = 3'd4,
    OP_NONE5  = 3'd5,
    OP_NONE6  = 3'd6,
    OP_NONE7  = 3'd7
  } nxa_op_e;

  typedef enum logic [1:0] {
    TGT_REL8  = 2'd0,
    TGT_REL16 = 2'd1,
    TGT_ABS   = 2'd2,
    TGT_FAR   = 2'd3
  } nxa_tgt_e;

endpackage

// File: rtl/nxa_target.sv
module nxa_target
  import nxa_pkg::*;
#(
  parameter int unsigned IP_W    = 16,
  parameter int unsigned CS_W    = 16,
  parameter int unsigned SHORT_W = 8
) (
  input  nxa_tgt_e               tgt,
  input  logic [CS_W-1:0]        cs,
  input  logic [IP_W-1:0]        ip,
  input  logic [IP_W-1:0]        disp,
  input  logic [IP_W-1:0]        near_tgt,
  input  logic [CS_W+IP_W-1:0]   far_ptr,
  output logic [CS_W-1:0]        tgt_cs,
  output logic [IP_W-1:0]        tgt_ip
);

  localparam int unsigned EXT_W = IP_W - SHORT_W;

  // modular add of an offset to the pointer
  function automatic logic [IP_W-1:0] ptr_add(input logic [IP_W-1:0] base,
                                              input logic [IP_W-1:0] ofs);
    return base + ofs;
  endfunction

  logic [IP_W-1:0] short_ext;

  generate
    if (EXT_W > 0) begin : g_ext
      assign short_ext = {{EXT_W{disp[SHORT_W-1]}}, disp[SHORT_W-1:0]};
    end else begin : g_noext
      assign short_ext = disp;
    end
  endgenerate

  always_comb begin
    tgt_cs = cs;
    tgt_ip = ip;
    unique case (tgt)
      TGT_REL8:  tgt_ip = ptr_add(ip, short_ext);
      TGT_REL16: tgt_ip = ptr_add(ip, disp);
      TGT_ABS:   tgt_ip = near_tgt;
      TGT_FAR: begin
        tgt_cs = far_ptr[CS_W+IP_W-1:IP_W];
        tgt_ip = far_ptr[IP_W-1:0];
      end
      default: tgt_ip = ip;
    endcase
  end

endmodule

// File: rtl/nxa_loop_ctl.sv
module nxa_loop_ctl
  import nxa_pkg::*;
#(
  parameter int unsigned CX_W = 16
) (
  input  nxa_op_e           op,
  input  logic [CX_W-1:0]   cx,
  input  logic              zf,
  output logic [CX_W-1:0]   cx_dec,
  output logic              is_loop,
  output logic              loop_go
);

  function automatic logic [CX_W-1:0] count_down(input logic [CX_W-1:0] v);
    return v - {{(CX_W-1){1'b0}}, 1'b1};
  endfunction

  logic cnt_live;

  assign cx_dec   = count_down(cx);
  assign cnt_live = |cx_dec;

  always_comb begin
    is_loop = 1'b0;
    loop_go = 1'b0;
    unique case (op)
      OP_LOOP: begin
        is_loop = 1'b1;
        loop_go = cnt_live;
      end
      OP_LOOPE: begin
        is_loop = 1'b1;
        loop_go = cnt_live & zf;
      end
      OP_LOOPNE: begin
        is_loop = 1'b1;
        loop_go = cnt_live & ~zf;
      end
      default: begin
        is_loop = 1'b0;
        loop_go = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/nxa_decide.sv
module nxa_decide
  import nxa_pkg::*;
(
  input  nxa_op_e op,
  input  logic    cond,
  input  logic    loop_go,
  output logic    take
);

  always_comb begin
    unique case (op)
      OP_JMP:                     take = 1'b1;
      OP_JCC:                     take = cond;
      OP_LOOP, OP_LOOPE, OP_LOOPNE: take = loop_go;
      default:                    take = 1'b0;
    endcase
  end

endmodule

// File: rtl/nxa_unit.sv
module nxa_unit
  import nxa_pkg::*;
#(
  parameter int unsigned IP_W    = 16,
  parameter int unsigned CS_W    = 16,
  parameter int unsigned CX_W    = 16,
  parameter int unsigned SHORT_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [2:0]            op_i,
  input  logic [1:0]            tgt_i,
  input  logic                  cond_i,
  input  logic                  zf_i,
  input  logic [CS_W-1:0]       cs_i,
  input  logic [IP_W-1:0]       ip_i,
  input  logic [IP_W-1:0]       fall_ip_i,
  input  logic [IP_W-1:0]       disp_i,
  input  logic [IP_W-1:0]       near_tgt_i,
  input  logic [CS_W+IP_W-1:0]  far_ptr_i,
  input  logic [CX_W-1:0]       cx_i,
  output logic [CS_W-1:0]       next_cs_o,
  output logic [IP_W-1:0]       next_ip_o,
  output logic [CX_W-1:0]       cx_o,
  output logic                  taken_o
);

  localparam int unsigned FAR_W = CS_W + IP_W;

  nxa_op_e         op_w;
  nxa_tgt_e        tgt_w;
  logic [CS_W-1:0] tgt_cs_w;
  logic [IP_W-1:0] tgt_ip_w;
  logic [CX_W-1:0] cx_dec_w;
  logic            is_loop_w;
  logic            loop_go_w;
  logic            take_w;

  assign op_w  = nxa_op_e'(op_i);
  assign tgt_w = nxa_tgt_e'(tgt_i);

  nxa_target #(.IP_W(IP_W), .CS_W(CS_W), .SHORT_W(SHORT_W)) u_target (
    .tgt      (tgt_w),
    .cs       (cs_i),
    .ip       (ip_i),
    .disp     (disp_i),
    .near_tgt (near_tgt_i),
    .far_ptr  (far_ptr_i),
    .tgt_cs   (tgt_cs_w),
    .tgt_ip   (tgt_ip_w)
  );

  nxa_loop_ctl #(.CX_W(CX_W)) u_loop (
    .op      (op_w),
    .cx      (cx_i),
    .zf      (zf_i),
    .cx_dec  (cx_dec_w),
    .is_loop (is_loop_w),
    .loop_go (loop_go_w)
  );

  nxa_decide u_decide (
    .op      (op_w),
    .cond    (cond_i),
    .loop_go (loop_go_w),
    .take    (take_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_cs_o <= '0;
      next_ip_o <= '0;
      cx_o      <= '0;
      taken_o   <= 1'b0;
    end else begin
      next_cs_o <= take_w ? tgt_cs_w : cs_i;
      next_ip_o <= take_w ? tgt_ip_w : fall_ip_i;
      cx_o      <= is_loop_w ? cx_dec_w : cx_i;
      taken_o   <= take_w;
    end
  end

  // ---------------- assertions ----------------
  assert_jmp_taken_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 3'd0) |=> taken_o);

  assert_jcc_false_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 3'd1 && !cond_i) |=> !taken_o);

  assert_near_keeps_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (take_w && tgt_i != 2'd3) |=> (next_cs_o == $past(cs_i)));

  assert_abs_ip_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take_w && tgt_i == 2'd2) |=> (next_ip_o == $past(near_tgt_i)));

  assert_far_split_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (take_w && tgt_i == 2'd3) |=>
      (next_cs_o == $past(far_ptr_i[FAR_W-1:IP_W]) && next_ip_o == $past(far_ptr_i[IP_W-1:0])));

  assert_loop_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (is_loop_w && cx_i == CX_W'(1)) |=> (!taken_o && cx_o == '0));

  assert_loope_zf_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 3'd3 && !zf_i) |=> !taken_o);

  assert_loopne_zf_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 3'd4 && zf_i) |=> !taken_o);

  assert_fall_through_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !take_w |=> (next_ip_o == $past(fall_ip_i) && next_cs_o == $past(cs_i)));

  assert_cx_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !is_loop_w |=> (cx_o == $past(cx_i)));

  assert_none_never_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i >= 3'd5) |=> !taken_o);

endmodule

// File: tb/sim_nxa_unit.sv
module sim_nxa_unit;

  logic        clk;
  logic        rst_n;
  logic [2:0]  op_i;
  logic [1:0]  tgt_i;
  logic        cond_i;
  logic        zf_i;
  logic [15:0] cs_i, ip_i, fall_ip_i, disp_i, near_tgt_i, cx_i;
  logic [31:0] far_ptr_i;
  logic [15:0] next_cs_o, next_ip_o, cx_o;
  logic        taken_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  nxa_unit u0 (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .tgt_i(tgt_i), .cond_i(cond_i),
    .zf_i(zf_i), .cs_i(cs_i), .ip_i(ip_i), .fall_ip_i(fall_ip_i),
    .disp_i(disp_i), .near_tgt_i(near_tgt_i), .far_ptr_i(far_ptr_i),
    .cx_i(cx_i), .next_cs_o(next_cs_o), .next_ip_o(next_ip_o),
    .cx_o(cx_o), .taken_o(taken_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // independent reference: written from the requirement text
  task automatic apply(input string req, input logic [2:0] op, input logic [1:0] tg,
                       input logic cnd, input logic z, input logic [15:0] cs,
                       input logic [15:0] ip, input logic [15:0] fall,
                       input logic [15:0] d, input logic [15:0] nt,
                       input logic [31:0] fp, input logic [15:0] cx);
    logic [15:0] e_cs, e_ip, e_cx, t_cs, t_ip, held_ip;
    logic        e_tk;
    int          sd;
    e_cx = cx;
    e_tk = 0;
    case (op)
      3'd0: e_tk = 1;
      3'd1: e_tk = cnd;
      3'd2: begin e_cx = cx - 16'd1; e_tk = (e_cx != 0); end
      3'd3: begin e_cx = cx - 16'd1; e_tk = (e_cx != 0) && z; end
      3'd4: begin e_cx = cx - 16'd1; e_tk = (e_cx != 0) && !z; end
      default: e_tk = 0;
    endcase
    t_cs = cs;
    case (tg)
      2'd0: begin
        sd = (d[7:0] >= 8'd128) ? int'(d[7:0]) - 256 : int'(d[7:0]);
        t_ip = 16'((int'(ip) + sd) & 16'hFFFF);
      end
      2'd1: t_ip = 16'((32'(ip) + 32'(d)) % 32'h10000);
      2'd2: t_ip = nt;
      default: begin t_cs = fp / 32'h10000; t_ip = fp % 32'h10000; end
    endcase
    e_cs = e_tk ? t_cs : cs;
    e_ip = e_tk ? t_ip : fall;
    @(negedge clk);
    held_ip = next_ip_o;
    op_i = op; tgt_i = tg; cond_i = cnd; zf_i = z; cs_i = cs; ip_i = ip;
    fall_ip_i = fall; disp_i = d; near_tgt_i = nt; far_ptr_i = fp; cx_i = cx;
    #1;
    chk("R11", "ip held before edge", {16'h0, next_ip_o}, {16'h0, held_ip});
    @(posedge clk);
    #1;
    chk(req, "taken", {31'h0, taken_o}, {31'h0, e_tk});
    chk(req, "cs",    {16'h0, next_cs_o}, {16'h0, e_cs});
    chk(req, "ip",    {16'h0, next_ip_o}, {16'h0, e_ip});
    chk(req, "cx",    {16'h0, cx_o},      {16'h0, e_cx});
  endtask

  task automatic t_reset();
    rst_n = 0;
    op_i = 3'd0; tgt_i = 2'd3; cond_i = 1; zf_i = 1; cs_i = 16'hAAAA;
    ip_i = 16'h1111; fall_ip_i = 16'h2222; disp_i = 16'h0; near_tgt_i = 16'h0;
    far_ptr_i = 32'hDEADBEEF; cx_i = 16'h5;
    repeat (3) @(posedge clk);
    #1;
    chk("R11", "reset taken", {31'h0, taken_o}, 32'h0);
    chk("R11", "reset cs",    {16'h0, next_cs_o}, 32'h0);
    chk("R11", "reset ip",    {16'h0, next_ip_o}, 32'h0);
    chk("R11", "reset cx",    {16'h0, cx_o}, 32'h0);
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic t_jumps();
    apply("R1 R3 rel8 negative", 3'd0, 2'd0, 0, 0, 16'h0100, 16'h1000, 16'h1003, 16'h00F0, 16'h0, 32'h0, 16'h0007);
    apply("R3 rel8 wrap",        3'd0, 2'd0, 0, 0, 16'h0100, 16'hFFF8, 16'hFFFA, 16'hFF10, 16'h0, 32'h0, 16'h0007);
    apply("R3 rel16 wrap",       3'd0, 2'd1, 0, 0, 16'h0200, 16'h8000, 16'h8003, 16'h9000, 16'h0, 32'h0, 16'h0001);
    apply("R4 absolute",         3'd0, 2'd2, 0, 0, 16'h0300, 16'h4000, 16'h4002, 16'h0012, 16'hBEEF, 32'h0, 16'h0009);
    apply("R5 far",              3'd0, 2'd3, 0, 0, 16'h0300, 16'h4000, 16'h4005, 16'h0, 16'h0, 32'h1234_5678, 16'h0009);
  endtask

  task automatic t_cond();
    apply("R2 cond true",   3'd1, 2'd0, 1, 0, 16'h0010, 16'h0500, 16'h0502, 16'h0020, 16'h0, 32'h0, 16'h0003);
    apply("R2 R9 cond false", 3'd1, 2'd0, 0, 1, 16'h0010, 16'h0500, 16'h0502, 16'h0020, 16'h0, 32'h0, 16'h0003);
    apply("R2 R5 cond far false", 3'd1, 2'd3, 0, 0, 16'h0010, 16'h0500, 16'h0505, 16'h0, 16'h0, 32'hCAFE_0040, 16'h0003);
  endtask

  task automatic t_loop();
    apply("R6 loop cx=5",  3'd2, 2'd0, 0, 0, 16'h0020, 16'h0600, 16'h0602, 16'h00FA, 16'h0, 32'h0, 16'h0005);
    apply("R6 loop cx=1",  3'd2, 2'd0, 0, 0, 16'h0020, 16'h0600, 16'h0602, 16'h00FA, 16'h0, 32'h0, 16'h0001);
    apply("R6 loop cx=0",  3'd2, 2'd0, 0, 0, 16'h0020, 16'h0600, 16'h0602, 16'h00FA, 16'h0, 32'h0, 16'h0000);
    apply("R7 loope zf1",  3'd3, 2'd0, 0, 1, 16'h0020, 16'h0700, 16'h0702, 16'h00F0, 16'h0, 32'h0, 16'h0003);
    apply("R7 loope zf0",  3'd3, 2'd0, 0, 0, 16'h0020, 16'h0700, 16'h0702, 16'h00F0, 16'h0, 32'h0, 16'h0003);
    apply("R7 loope cx=1", 3'd3, 2'd0, 0, 1, 16'h0020, 16'h0700, 16'h0702, 16'h00F0, 16'h0, 32'h0, 16'h0001);
    apply("R8 loopne zf0", 3'd4, 2'd0, 0, 0, 16'h0020, 16'h0800, 16'h0802, 16'h0010, 16'h0, 32'h0, 16'h0004);
    apply("R8 loopne zf1", 3'd4, 2'd0, 0, 1, 16'h0020, 16'h0800, 16'h0802, 16'h0010, 16'h0, 32'h0, 16'h0004);
  endtask

  task automatic t_none();
    apply("R10 R9 op5", 3'd5, 2'd3, 1, 1, 16'h0040, 16'h0900, 16'h0903, 16'h0, 16'h0, 32'h7777_8888, 16'h0001);
    apply("R10 op7",    3'd7, 2'd2, 1, 0, 16'h0040, 16'h0900, 16'h0904, 16'h0, 16'h1234, 32'h0, 16'h0000);
    apply("R10 jcc cx", 3'd1, 2'd1, 1, 0, 16'h0040, 16'h0900, 16'h0904, 16'h0100, 16'h0, 32'h0, 16'h0042);
  endtask

  initial begin
    t_reset();
    t_jumps();
    t_cond();
    t_loop();
    t_none();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule